// File: doc/BRIEF.md
# Hardware power-domain vote controller

This block lets several requesters share a set of power domains. The requesters can be an application processor or remote processors. A requester asks for a domain to be powered by writing a one to that domain's bit in a command register. The block keeps one vote bit for each requester and each domain. A single sequencer works through the accepted commands one at a time. When a command changes the combined vote of a domain, the sequencer drives that domain's switch-enable output. It then waits for the matching acknowledge input. A switch-off also waits through a fixed settling interval.

Requesters reach the block through a simple register port, made of a write strobe, a word address, write data and a requester identifier. Reads are combinational. Each domain has the same bit position in every register. A command is followed through several readbacks. The command bit itself shows when the sequencer has picked the command up. Per-domain busy flags show when the command has finished, and an idle flag shows when the domain can take a new command. The combined vote of each domain can also be read.

Top module: `hwv_vote_ctrl`

## Requirements
- R1: After reset, every switch-enable output is 0. The EN, SET_STA, CLR_STA and both command readbacks read 0, and DONE reads 1 for every domain.
- R2: The block takes a power-on write only for domains whose DONE bit is 1. The SET readback bit of a taken domain reads 0 in the cycle after the write. It reads 1 from the cycle after the sequencer starts that command, which is one cycle after the write when the sequencer is idle.
- R3: A power-on that changes the combined vote raises the domain's enable output when the command starts. The command completes in the cycle after the acknowledge is seen high. Completion means DONE=1, EN=1 and SET_STA=0 for that domain.
- R4: The CLR readback bit of a taken power-off write reads 1 after the write. It returns to 0 once the sequencer starts that command.
- R5: From acceptance until completion, the domain's SET_STA or CLR_STA bit reads 1 and its DONE bit reads 0.
- R6: EN of a domain is the OR of all requesters' votes. A domain's enable output falls only when no requester still votes for it.
- R7: A power-off that drops the combined vote lowers the enable output at the start of the command. It then waits STAB_CYC cycles before it samples the acknowledge, so it completes no earlier than STAB_CYC+2 cycles after the write.
- R8: A command that leaves the combined vote unchanged completes one cycle after the write and does not toggle the enable output.
- R9: The block ignores a command written for a domain whose DONE bit is 0. No vote is recorded and no status bit changes.
- R10: Writing 0 bits has no effect. The block ignores writes to EN, DONE, SET_STA, CLR_STA and to unmapped addresses.
- R11: Pending commands run one at a time, in ascending domain order. At most one enable output changes in any cycle.
- R12: The register word addresses are: 0 power-on command (SET), 1 power-off command (CLR), 2 EN, 3 DONE, 4 SET_STA, 5 CLR_STA. Domain d uses bit d in each of them, and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_we_i | input | 1 | Write strobe |
| bus_addr_i | input | ADDR_W | Register word address |
| bus_wdata_i | input | DATA_W | Write data, one bit per domain |
| bus_req_i | input | $clog2(N_REQ) | Identifier of the writing requester |
| bus_rdata_o | output | DATA_W | Read data for bus_addr_i |
| pwr_en_o | output | N_DOM | Per-domain switch enable |
| pwr_ack_i | input | N_DOM | Per-domain switch acknowledge |

## Verification
The hardest case to reach from the ports is a command that arrives while its domain is still busy. Such a command must leave no trace, and any trace it left would only show up much later. The stimulus writes a power-on and then, during the acknowledge wait, writes a power-off and a power-on from a second requester for the same domain. A later power-off by the first requester must then really switch the domain off: a stray vote would hold it on. Ordering is reached with a single write that asks for three domains at once. A scoreboard of expected enable toggles then checks the order in which the switches move.

// File: rtl/hwv_pkg.sv
package hwv_pkg;
  localparam int A_SET     = 0;
  localparam int A_CLR     = 1;
  localparam int A_EN      = 2;
  localparam int A_DONE    = 3;
  localparam int A_SET_STA = 4;
  localparam int A_CLR_STA = 5;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_WAIT_ON,
    SQ_STAB,
    SQ_WAIT_OFF
  } seq_state_e;
endpackage

// File: rtl/hwv_cmd_regs.sv
module hwv_cmd_regs #(
  parameter int N_DOM  = 8,
  parameter int N_REQ  = 4,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4,
  localparam int RID_W = $clog2(N_REQ),
  localparam int IDX_W = (N_DOM > 1) ? $clog2(N_DOM) : 1
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        bus_we_i,
  input  logic [ADDR_W-1:0]           bus_addr_i,
  input  logic [DATA_W-1:0]           bus_wdata_i,
  input  logic [RID_W-1:0]            bus_req_i,
  output logic [DATA_W-1:0]           bus_rdata_o,
  input  logic                        seq_start_i,
  input  logic                        seq_fin_i,
  input  logic                        seq_on_i,
  input  logic [IDX_W-1:0]            seq_idx_i,
  input  logic [N_DOM-1:0]            en_i,
  output logic [N_DOM-1:0]            set_sta_o,
  output logic [N_DOM-1:0]            clr_sta_o,
  output logic [N_DOM-1:0][RID_W-1:0] req_tab_o
);
  import hwv_pkg::*;

  logic [N_DOM-1:0] set_sta_q, clr_sta_q, set_rb_q, clr_rb_q;
  logic [N_DOM-1:0] done, acc_set, acc_clr, start_vec, fin_vec;
  logic [N_DOM-1:0] wbits;
  logic [N_DOM-1:0][RID_W-1:0] req_q;

  assign wbits = bus_wdata_i[N_DOM-1:0];

  if (DATA_W > N_DOM) begin : g_unused
    logic unused_hi;
    assign unused_hi = ^bus_wdata_i[DATA_W-1:N_DOM];
  end

  assign done      = ~(set_sta_q | clr_sta_q);
  assign acc_set   = (bus_we_i && bus_addr_i == ADDR_W'(A_SET)) ? (wbits & done) : '0;
  assign acc_clr   = (bus_we_i && bus_addr_i == ADDR_W'(A_CLR)) ? (wbits & done) : '0;
  assign start_vec = seq_start_i ? (N_DOM'(1) << seq_idx_i) : '0;
  assign fin_vec   = seq_fin_i ? (N_DOM'(1) << seq_idx_i) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      set_sta_q <= '0;
      clr_sta_q <= '0;
      set_rb_q  <= '0;
      clr_rb_q  <= '0;
    end else begin
      set_sta_q <= (set_sta_q & ~fin_vec) | acc_set;
      clr_sta_q <= (clr_sta_q & ~fin_vec) | acc_clr;
      // set readback drops on write, returns when the sequencer picks it up
      set_rb_q  <= (set_rb_q & ~acc_set) | (start_vec & {N_DOM{seq_on_i}});
      // clr readback holds until pickup
      clr_rb_q  <= (clr_rb_q | acc_clr) & ~(start_vec & {N_DOM{~seq_on_i}});
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= '0;
    end else begin
      for (int d = 0; d < N_DOM; d++) begin
        if (acc_set[d] || acc_clr[d]) req_q[d] <= bus_req_i;
      end
    end
  end

  always_comb begin
    case (bus_addr_i)
      ADDR_W'(A_SET):     bus_rdata_o = DATA_W'(set_rb_q);
      ADDR_W'(A_CLR):     bus_rdata_o = DATA_W'(clr_rb_q);
      ADDR_W'(A_EN):      bus_rdata_o = DATA_W'(en_i);
      ADDR_W'(A_DONE):    bus_rdata_o = DATA_W'(done);
      ADDR_W'(A_SET_STA): bus_rdata_o = DATA_W'(set_sta_q);
      ADDR_W'(A_CLR_STA): bus_rdata_o = DATA_W'(clr_sta_q);
      default:            bus_rdata_o = '0;
    endcase
  end

  assign set_sta_o = set_sta_q;
  assign clr_sta_o = clr_sta_q;
  assign req_tab_o = req_q;
endmodule

// File: rtl/hwv_vote_bank.sv
module hwv_vote_bank #(
  parameter int N_DOM = 8,
  parameter int N_REQ = 4,
  localparam int RID_W = $clog2(N_REQ),
  localparam int IDX_W = (N_DOM > 1) ? $clog2(N_DOM) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             upd_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [RID_W-1:0] req_i,
  input  logic             on_i,
  output logic [N_DOM-1:0] en_o,
  output logic             en_after_o
);
  logic [N_DOM-1:0][N_REQ-1:0] vote_q;
  logic [N_REQ-1:0] sel, sel_new, rbit;

  assign rbit       = N_REQ'(1) << req_i;
  assign sel        = vote_q[idx_i];
  assign sel_new    = on_i ? (sel | rbit) : (sel & ~rbit);
  assign en_after_o = |sel_new;

  for (genvar d = 0; d < N_DOM; d++) begin : g_dom
    assign en_o[d] = |vote_q[d];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vote_q <= '0;
    else if (upd_i) vote_q[idx_i] <= sel_new;
  end
endmodule

// File: rtl/hwv_seq.sv
module hwv_seq #(
  parameter int N_DOM    = 8,
  parameter int STAB_CYC = 5000,
  localparam int IDX_W = (N_DOM > 1) ? $clog2(N_DOM) : 1,
  localparam int CNT_W = $clog2(STAB_CYC + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_DOM-1:0] set_sta_i,
  input  logic [N_DOM-1:0] clr_sta_i,
  input  logic             en_after_i,
  input  logic [N_DOM-1:0] pwr_ack_i,
  output logic             start_o,
  output logic             fin_o,
  output logic             on_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [N_DOM-1:0] pwr_en_o
);
  import hwv_pkg::*;

  seq_state_e       state_q;
  logic [IDX_W-1:0] cur_q, pick;
  logic             op_q, idle, change;
  logic [CNT_W-1:0] cnt_q;
  logic [N_DOM-1:0] pwr_en_q, pend;

  assign pend = set_sta_i | clr_sta_i;

  // lowest pending index wins
  always_comb begin
    pick = '0;
    for (int d = N_DOM - 1; d >= 0; d--) begin
      if (pend[d]) pick = IDX_W'(d);
    end
  end

  assign idle    = (state_q == SQ_IDLE);
  assign idx_o   = idle ? pick : cur_q;
  assign on_o    = idle ? set_sta_i[pick] : op_q;
  assign start_o = idle && (|pend);
  assign change  = (en_after_i != pwr_en_q[idx_o]);

  always_comb begin
    fin_o = 1'b0;
    unique case (state_q)
      SQ_IDLE:     fin_o = start_o && !change;
      SQ_WAIT_ON:  fin_o = pwr_ack_i[cur_q];
      SQ_WAIT_OFF: fin_o = !pwr_ack_i[cur_q];
      default:     fin_o = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= SQ_IDLE;
      cur_q    <= '0;
      op_q     <= 1'b0;
      cnt_q    <= '0;
      pwr_en_q <= '0;
    end else begin
      unique case (state_q)
        SQ_IDLE: begin
          if (start_o && change) begin
            cur_q           <= pick;
            op_q            <= on_o;
            pwr_en_q[pick]  <= en_after_i;
            cnt_q           <= CNT_W'(STAB_CYC - 1);
            state_q         <= on_o ? SQ_WAIT_ON : SQ_STAB;
          end
        end
        SQ_WAIT_ON:  if (pwr_ack_i[cur_q]) state_q <= SQ_IDLE;
        SQ_STAB: begin
          if (cnt_q == '0) state_q <= SQ_WAIT_OFF;
          else             cnt_q   <= cnt_q - 1'b1;
        end
        SQ_WAIT_OFF: if (!pwr_ack_i[cur_q]) state_q <= SQ_IDLE;
        default:     state_q <= SQ_IDLE;
      endcase
    end
  end

  assign pwr_en_o = pwr_en_q;
endmodule

// File: rtl/hwv_vote_ctrl.sv
module hwv_vote_ctrl #(
  parameter int N_DOM    = 8,
  parameter int N_REQ    = 4,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 4,
  parameter int STAB_CYC = 5000
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     bus_we_i,
  input  logic [ADDR_W-1:0]        bus_addr_i,
  input  logic [DATA_W-1:0]        bus_wdata_i,
  input  logic [$clog2(N_REQ)-1:0] bus_req_i,
  output logic [DATA_W-1:0]        bus_rdata_o,
  output logic [N_DOM-1:0]         pwr_en_o,
  input  logic [N_DOM-1:0]         pwr_ack_i
);
  localparam int RID_W = $clog2(N_REQ);
  localparam int IDX_W = (N_DOM > 1) ? $clog2(N_DOM) : 1;

  logic [N_DOM-1:0] set_sta, clr_sta, en_vote;
  logic [N_DOM-1:0][RID_W-1:0] req_tab;
  logic             seq_start, seq_fin, seq_on, en_after;
  logic [IDX_W-1:0] seq_idx;

  hwv_cmd_regs #(
    .N_DOM(N_DOM), .N_REQ(N_REQ), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_we_i    (bus_we_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_req_i   (bus_req_i),
    .bus_rdata_o (bus_rdata_o),
    .seq_start_i (seq_start),
    .seq_fin_i   (seq_fin),
    .seq_on_i    (seq_on),
    .seq_idx_i   (seq_idx),
    .en_i        (en_vote),
    .set_sta_o   (set_sta),
    .clr_sta_o   (clr_sta),
    .req_tab_o   (req_tab)
  );

  hwv_vote_bank #(.N_DOM(N_DOM), .N_REQ(N_REQ)) u_votes (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .upd_i      (seq_start),
    .idx_i      (seq_idx),
    .req_i      (req_tab[seq_idx]),
    .on_i       (seq_on),
    .en_o       (en_vote),
    .en_after_o (en_after)
  );

  hwv_seq #(.N_DOM(N_DOM), .STAB_CYC(STAB_CYC)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_sta_i  (set_sta),
    .clr_sta_i  (clr_sta),
    .en_after_i (en_after),
    .pwr_ack_i  (pwr_ack_i),
    .start_o    (seq_start),
    .fin_o      (seq_fin),
    .on_o       (seq_on),
    .idx_o      (seq_idx),
    .pwr_en_o   (pwr_en_o)
  );
endmodule

// File: rtl/hwv_vote_ctrl_chk.sv
module hwv_vote_ctrl_chk #(
  parameter int N_DOM    = 8,
  parameter int STAB_CYC = 5000
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_DOM-1:0] pwr_en_o,
  input logic [N_DOM-1:0] pwr_ack_i,
  input logic [N_DOM-1:0] set_sta,
  input logic [N_DOM-1:0] clr_sta,
  input logic [N_DOM-1:0] en_vote
);
  logic [N_DOM-1:0] en_prev;
  logic [31:0]      off_age;

  // cycles since the most recent enable fall
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_prev <= '0;
      off_age <= '1;
    end else begin
      en_prev <= pwr_en_o;
      if (|(en_prev & ~pwr_en_o))  off_age <= 32'd1;
      else if (off_age != '1)      off_age <= off_age + 1;
    end
  end

  p_one_switch_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(pwr_en_o ^ $past(pwr_en_o)) <= 1);

  p_rise_in_on_cmd_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_en_o & ~$past(pwr_en_o) & ~set_sta) == '0);

  p_fall_no_vote_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (~pwr_en_o & $past(pwr_en_o) & (en_vote | ~clr_sta)) == '0);

  p_on_done_acked_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (~set_sta & $past(set_sta) & ~(pwr_en_o & $past(pwr_ack_i))) == '0);

  p_off_done_released_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (~clr_sta & $past(clr_sta) & ~pwr_en_o & $past(pwr_ack_i)) == '0);

  p_off_settle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((~clr_sta & $past(clr_sta) & ~pwr_en_o) != '0) |-> (off_age >= 32'(STAB_CYC)));
endmodule

bind hwv_vote_ctrl hwv_vote_ctrl_chk #(.N_DOM(N_DOM), .STAB_CYC(STAB_CYC)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .pwr_en_o  (pwr_en_o),
  .pwr_ack_i (pwr_ack_i),
  .set_sta   (set_sta),
  .clr_sta   (clr_sta),
  .en_vote   (en_vote)
);

// File: tb/hwv_vote_ctrl_test.sv
module hwv_vote_ctrl_test;
  localparam int N_DOM = 8;
  localparam int STAB  = 16;
  localparam int A_SET = 0, A_CLR = 1, A_EN = 2, A_DONE = 3, A_SSTA = 4, A_CSTA = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [1:0]  req = '0;
  logic [31:0] rdata;
  logic [N_DOM-1:0] pwr_en;
  logic [N_DOM-1:0] a1 = '0, a2 = '0, a3 = '0;

  int n_chk = 0;
  int n_fail = 0;
  int exp_q[$];
  logic [N_DOM-1:0] mon_prev = '0;

  always #10 clk = ~clk;

  // switch model: acknowledge follows enable after three cycles
  always @(posedge clk) begin
    a1 <= pwr_en;
    a2 <= a1;
    a3 <= a2;
  end

  hwv_vote_ctrl #(.N_DOM(N_DOM), .N_REQ(4), .DATA_W(32), .ADDR_W(4), .STAB_CYC(STAB)) uut (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_req_i(req), .bus_rdata_o(rdata),
    .pwr_en_o(pwr_en), .pwr_ack_i(a3)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: every enable toggle must match the next expected item
  always @(negedge clk) begin
    if (rst_n) begin
      for (int d = 0; d < N_DOM; d++) begin
        if (pwr_en[d] !== mon_prev[d]) begin
          if (exp_q.size() == 0) chk("R8 R11 unexpected toggle", d * 2 + pwr_en[d], 32'hffff);
          else chk("R11 toggle order", d * 2 + pwr_en[d], exp_q.pop_front());
        end
      end
      mon_prev = pwr_en;
    end
  end

  task automatic wr(int a, logic [31:0] d, int r);
    @(negedge clk);
    we = 1'b1; addr = 4'(a); wdata = d; req = 2'(r);
    @(posedge clk);
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    addr = 4'(a);
    #1;
    d = rdata;
  endtask

  task automatic wait_done(logic [31:0] mask, int start, output int cyc);
    logic [31:0] v;
    cyc = start;
    for (int i = 0; i < 400; i++) begin
      rd(A_DONE, v);
      if ((v & mask) == mask) break;
      @(negedge clk);
      cyc++;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int cyc;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state, R12 map
    rd(A_SET, v);  chk("R1 set rb", v, 0);
    rd(A_CLR, v);  chk("R1 clr rb", v, 0);
    rd(A_EN, v);   chk("R1 en", v, 0);
    rd(A_DONE, v); chk("R1 done", v, 32'hff);
    rd(A_SSTA, v); chk("R1 set_sta", v, 0);
    rd(A_CSTA, v); chk("R1 clr_sta", v, 0);
    chk("R1 pwr_en", 32'(pwr_en), 0);
    rd(7, v);      chk("R12 unmapped", v, 0);

    // R2 R3 R5 first power-on of domain 2
    exp_q.push_back(2 * 2 + 1);
    wr(A_SET, 32'h04, 0);
    rd(A_SET, v);  chk("R2 set rb drops", v[2], 0);
    rd(A_SSTA, v); chk("R5 set_sta busy", v[2], 1);
    rd(A_DONE, v); chk("R5 done low", v[2], 0);
    @(negedge clk);
    rd(A_SET, v);  chk("R2 set rb returns", v[2], 1);
    chk("R3 pwr_en raised at start", pwr_en[2], 1);
    wait_done(32'h04, 1, cyc);
    chk("R3 on latency", cyc, 5);
    rd(A_EN, v);   chk("R3 en", v, 32'h04);
    rd(A_SSTA, v); chk("R3 set_sta cleared", v, 0);

    // R8 second vote, no state change
    wr(A_SET, 32'h04, 1);
    wait_done(32'h04, 0, cyc);
    chk("R8 single cycle", cyc, 1);
    rd(A_EN, v);   chk("R8 en kept", v, 32'h04);

    // R4 R6 first requester leaves, other still votes
    wr(A_CLR, 32'h04, 0);
    rd(A_CLR, v);  chk("R4 clr rb high", v[2], 1);
    rd(A_CSTA, v); chk("R5 clr_sta busy", v[2], 1);
    wait_done(32'h04, 0, cyc);
    chk("R8 R6 single cycle", cyc, 1);
    rd(A_CLR, v);  chk("R4 clr rb cleared", v[2], 0);
    rd(A_EN, v);   chk("R6 en kept", v, 32'h04);
    chk("R6 pwr_en kept", pwr_en[2], 1);

    // R7 last vote gone
    exp_q.push_back(2 * 2 + 0);
    wr(A_CLR, 32'h04, 1);
    @(negedge clk);
    chk("R7 pwr_en fell at start", pwr_en[2], 0);
    rd(A_DONE, v); chk("R7 done low in settle", v[2], 0);
    wait_done(32'h04, 1, cyc);
    chk("R7 off latency", cyc, STAB + 2);
    rd(A_EN, v);   chk("R7 en", v, 0);

    // R9 writes to a busy domain
    exp_q.push_back(0 * 2 + 1);
    wr(A_SET, 32'h01, 2);
    wr(A_CLR, 32'h01, 2);
    wr(A_SET, 32'h01, 3);
    rd(A_CLR, v);  chk("R9 clr rb untouched", v[0], 0);
    wait_done(32'h01, 0, cyc);
    rd(A_CSTA, v); chk("R9 clr_sta untouched", v, 0);
    rd(A_EN, v);   chk("R9 en", v, 32'h01);
    exp_q.push_back(0 * 2 + 0);
    wr(A_CLR, 32'h01, 2);
    wait_done(32'h01, 0, cyc);
    chk("R9 no stray vote, full off", cyc, STAB + 2);
    rd(A_EN, v);   chk("R9 en off", v, 0);

    // R10 zero bits and read-only registers
    wr(A_SET, 32'h00, 1);
    wr(A_EN, 32'hff, 1);
    wr(A_DONE, 32'h00, 1);
    wr(A_SSTA, 32'hff, 1);
    wr(A_CSTA, 32'hff, 1);
    wr(7, 32'hff, 1);
    @(negedge clk);
    rd(A_EN, v);   chk("R10 en", v, 0);
    rd(A_DONE, v); chk("R10 done", v, 32'hff);
    rd(A_SSTA, v); chk("R10 set_sta", v, 0);
    rd(A_CSTA, v); chk("R10 clr_sta", v, 0);
    chk("R10 pwr_en", 32'(pwr_en), 0);

    // R11 batch ordering
    exp_q.push_back(1 * 2 + 1);
    exp_q.push_back(3 * 2 + 1);
    exp_q.push_back(5 * 2 + 1);
    wr(A_SET, 32'h2a, 2);
    wait_done(32'hff, 0, cyc);
    chk("R11 batch on cycles", cyc, 15);
    rd(A_EN, v);   chk("R11 en", v, 32'h2a);
    exp_q.push_back(1 * 2 + 0);
    exp_q.push_back(3 * 2 + 0);
    exp_q.push_back(5 * 2 + 0);
    wr(A_CLR, 32'h2a, 2);
    wait_done(32'hff, 0, cyc);
    chk("R11 R7 batch off cycles", cyc, 3 * STAB + 6);
    rd(A_EN, v);   chk("R11 en off", v, 0);
    repeat (2) @(negedge clk);
    chk("R11 scoreboard drained", exp_q.size(), 0);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule